// File: doc/BRIEF.md
# Two-Level Warp Issue Scheduler

This block picks, once per clock, the single warp whose next buffered instruction goes to an execution pipe. The warps it serves are split into two ordered lists. The active list is bounded by a parameter and is the only one the issue logic looks at. The pending list holds every other warp in first-in, first-out order. Warps whose next instruction waits on a long-latency result are moved out of the active list, so that they do not take issue slots from warps that could make progress.

Each cycle the block works in three steps, all in one cycle. First it demotes at most one stalled active warp to the back of the pending list. Then, if the active list has room, it promotes at most one non-waiting pending warp to the back of the active list. Last, it scans the updated active list from its head and dispatches the first instruction that is ready and whose pipe is free, to the SP, SFU or memory pipe. The warp that issues goes to the back of the active list. Warps that were scanned and found to have a program-counter mismatch get a flush request. Instruction fetch and the scoreboard are outside the block: their results come in as per-warp flags.

Top module: `tl_warp_sched`

## Requirements
- R1: After reset, warps 0 to MAX_ACTIVE-1 form the active list in ascending id order and the rest form the pending list in ascending id order. While reset is held, issue_vld and flush_req are 0.
- R2: Only a warp on the active list can issue. A ready warp on the pending list never issues while it stays pending.
- R3: In each cycle at most one warp is demoted: the first warp in active order that has warp_wait set or a long-latency source. It moves to the tail of the pending list.
- R4: A source slot counts as long-latency only when its src_long bit is 1 and its src_idx field (slot s of warp w at bits (w*4+s)*SRC_IDX_W upward) is non-zero. A slot with index 0 never causes a demotion.
- R5: In each cycle at most one warp is promoted, and only when the active list (after demotion) holds fewer than MAX_ACTIVE warps. The promoted warp is the first pending warp with warp_wait clear, and it goes to the active tail.
- R6: A scanned active warp with warp_wait clear, inst_valid set and pc_match clear gets its flush_req bit set and does not issue. Scanning stops at the issuing warp, so warps behind it get no flush.
- R7: A warp with collide set does not issue, and the scan moves on to the next active warp.
- R8: Operation class 2'b11 (memory: load, store, barrier) issues only to the memory pipe (issue_pipe 2'b10), and only when mem_free is 1.
- R9: Class 2'b00 (ALU) issues only to SP (issue_pipe 2'b00) when sp_free is 1. Class 2'b01 (SFU) issues only to SFU (issue_pipe 2'b01) when sfu_free is 1. Class 2'b10 (ALU or SFU) goes to SP when sp_free is 1, otherwise to SFU when sfu_free is 1.
- R10: At most one instruction issues per cycle: the first eligible warp in the updated active order. The issuing warp then moves to the active tail.
- R11: issue_vld, issue_warp, issue_pipe and flush_req are registered. They show the decision made from the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_wait | input | NUM_WARPS | Per-warp waiting flag |
| inst_valid | input | NUM_WARPS | Per-warp next buffered instruction present |
| pc_match | input | NUM_WARPS | Per-warp instruction PC equals reconvergence top PC |
| op_class | input | 2*NUM_WARPS | Per-warp operation class, 2 bits each |
| collide | input | NUM_WARPS | Per-warp scoreboard register collision |
| src_idx | input | NUM_WARPS*NUM_SRC*SRC_IDX_W | Per-warp source register indices, 0 = slot unused |
| src_long | input | NUM_WARPS*NUM_SRC | Per-warp source long-latency flags |
| sp_free | input | 1 | SP pipe can accept |
| sfu_free | input | 1 | SFU pipe can accept |
| mem_free | input | 1 | Memory pipe can accept |
| issue_vld | output | 1 | An instruction issued |
| issue_warp | output | $clog2(NUM_WARPS) | Id of the issuing warp |
| issue_pipe | output | 2 | Target pipe: 00 SP, 01 SFU, 10 memory |
| flush_req | output | NUM_WARPS | Per-warp next-PC update and buffer flush request |

## Verification
The bound checker watches, on every cycle, that each issue goes to a legal pipe for the class the warp had in the sampled cycle and that this pipe was free. It also checks that the issuing warp was ready and free of collisions, that a flush request only follows a sampled PC mismatch and never lands on the issuing warp, and that the two list counts always add up to the number of warps. The ordering behaviour cannot be seen from one cycle of ports: which warp is demoted or promoted, the rotation after issue, and whether a pending warp is kept from issuing. Only the bench's scenarios show these, by comparing the issue sequence against a list model.

// File: rtl/tl_sched_pkg.sv
package tl_sched_pkg;

    typedef enum logic [1:0] {
        OP_ALU     = 2'b00,
        OP_SFU     = 2'b01,
        OP_ALU_SFU = 2'b10,
        OP_MEM     = 2'b11
    } op_class_e;

    typedef enum logic [1:0] {
        PIPE_SP  = 2'b00,
        PIPE_SFU = 2'b01,
        PIPE_MEM = 2'b10
    } pipe_sel_e;

endpackage

// File: rtl/tl_first_set.sv
// Lowest-position set bit of an ordered candidate mask.
module tl_first_set #(
    parameter int WIDTH = 8,
    parameter int POSW  = 4
) (
    input  logic [WIDTH-1:0] mask,
    output logic             hit,
    output logic [POSW-1:0]  pos
);
    always_comb begin
        hit = 1'b0;
        pos = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                hit = 1'b1;
                pos = POSW'(i);
            end
        end
    end
endmodule

// File: rtl/tl_warp_eval.sv
// Per-warp classification: stall for demotion, control hazard, issue readiness and pipe.
module tl_warp_eval
    import tl_sched_pkg::*;
#(
    parameter int NUM_SRC   = 4,
    parameter int SRC_IDX_W = 6
) (
    input  logic                         wait_i,
    input  logic                         valid_i,
    input  logic                         pc_ok_i,
    input  logic                         collide_i,
    input  logic [1:0]                   op_i,
    input  logic [NUM_SRC*SRC_IDX_W-1:0] src_idx_i,
    input  logic [NUM_SRC-1:0]           src_long_i,
    input  logic                         sp_free_i,
    input  logic                         sfu_free_i,
    input  logic                         mem_free_i,
    output logic                         stall_o,
    output logic                         hazard_o,
    output logic                         ready_o,
    output logic [1:0]                   pipe_o
);
    logic      long_dep;
    logic      cand;
    logic      go;
    pipe_sel_e pick;

    always_comb begin
        long_dep = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (src_long_i[s] && (src_idx_i[s*SRC_IDX_W +: SRC_IDX_W] != '0)) begin
                long_dep = 1'b1;
            end
        end
    end

    assign stall_o  = wait_i | long_dep;
    assign hazard_o = !wait_i && valid_i && !pc_ok_i;
    assign cand     = !wait_i && valid_i && pc_ok_i && !collide_i;

    always_comb begin
        go   = 1'b0;
        pick = PIPE_SP;
        unique case (op_class_e'(op_i))
            OP_MEM: begin
                go   = mem_free_i;
                pick = PIPE_MEM;
            end
            OP_SFU: begin
                go   = sfu_free_i;
                pick = PIPE_SFU;
            end
            OP_ALU: begin
                go   = sp_free_i;
                pick = PIPE_SP;
            end
            OP_ALU_SFU: begin
                go   = sp_free_i | sfu_free_i;
                pick = sp_free_i ? PIPE_SP : PIPE_SFU;
            end
            default: begin
                go   = 1'b0;
                pick = PIPE_SP;
            end
        endcase
    end

    assign ready_o = cand && go;
    assign pipe_o  = pick;
endmodule

// File: rtl/tl_warp_sched.sv
module tl_warp_sched
    import tl_sched_pkg::*;
#(
    parameter int NUM_WARPS  = 8,
    parameter int MAX_ACTIVE = 4,
    parameter int NUM_SRC    = 4,
    parameter int SRC_IDX_W  = 6
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_WARPS-1:0]                   warp_wait,
    input  logic [NUM_WARPS-1:0]                   inst_valid,
    input  logic [NUM_WARPS-1:0]                   pc_match,
    input  logic [2*NUM_WARPS-1:0]                 op_class,
    input  logic [NUM_WARPS-1:0]                   collide,
    input  logic [NUM_WARPS*NUM_SRC*SRC_IDX_W-1:0] src_idx,
    input  logic [NUM_WARPS*NUM_SRC-1:0]           src_long,
    input  logic                                   sp_free,
    input  logic                                   sfu_free,
    input  logic                                   mem_free,
    output logic                                   issue_vld,
    output logic [$clog2(NUM_WARPS)-1:0]           issue_warp,
    output logic [1:0]                             issue_pipe,
    output logic [NUM_WARPS-1:0]                   flush_req
);
    localparam int IDW = $clog2(NUM_WARPS);
    localparam int CW  = $clog2(NUM_WARPS + 1);
    localparam int SLW = NUM_SRC * SRC_IDX_W;

    // Ordered lists and their fill counts
    logic [IDW-1:0] act_q  [MAX_ACTIVE];
    logic [IDW-1:0] pend_q [NUM_WARPS];
    logic [CW-1:0]  act_cnt, pend_cnt;

    // Per-warp classification
    logic [NUM_WARPS-1:0] stall_w, hazard_w, ready_w;
    logic [1:0]           pipe_w [NUM_WARPS];

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_eval
        tl_warp_eval #(.NUM_SRC(NUM_SRC), .SRC_IDX_W(SRC_IDX_W)) i_eval (
            .wait_i     (warp_wait[w]),
            .valid_i    (inst_valid[w]),
            .pc_ok_i    (pc_match[w]),
            .collide_i  (collide[w]),
            .op_i       (op_class[2*w +: 2]),
            .src_idx_i  (src_idx[w*SLW +: SLW]),
            .src_long_i (src_long[w*NUM_SRC +: NUM_SRC]),
            .sp_free_i  (sp_free),
            .sfu_free_i (sfu_free),
            .mem_free_i (mem_free),
            .stall_o    (stall_w[w]),
            .hazard_o   (hazard_w[w]),
            .ready_o    (ready_w[w]),
            .pipe_o     (pipe_w[w])
        );
    end

    // Step 1: demotion
    logic [MAX_ACTIVE-1:0] dem_mask;
    logic                  dem_hit;
    logic [CW-1:0]         dem_pos;
    logic [IDW-1:0]        dem_w;
    logic [IDW-1:0]        act1  [MAX_ACTIVE];
    logic [IDW-1:0]        pend1 [NUM_WARPS];
    logic [CW-1:0]         act1_cnt, pend1_cnt;

    always_comb begin
        for (int i = 0; i < MAX_ACTIVE; i++) begin
            dem_mask[i] = (CW'(i) < act_cnt) && stall_w[act_q[i]];
        end
    end

    tl_first_set #(.WIDTH(MAX_ACTIVE), .POSW(CW)) i_dem_pick (
        .mask (dem_mask), .hit (dem_hit), .pos (dem_pos)
    );

    always_comb begin
        act1      = act_q;
        pend1     = pend_q;
        act1_cnt  = act_cnt;
        pend1_cnt = pend_cnt;
        dem_w     = '0;
        for (int k = 0; k < MAX_ACTIVE; k++) begin
            if (CW'(k) == dem_pos) dem_w = act_q[k];
        end
        if (dem_hit) begin
            for (int k = 0; k < MAX_ACTIVE - 1; k++) begin
                if (CW'(k) >= dem_pos) act1[k] = act_q[k+1];
            end
            for (int k = 0; k < NUM_WARPS; k++) begin
                if (CW'(k) == pend_cnt) pend1[k] = dem_w;
            end
            act1_cnt  = act_cnt - CW'(1);
            pend1_cnt = pend_cnt + CW'(1);
        end
    end

    // Step 2: promotion
    logic [NUM_WARPS-1:0] prom_mask;
    logic                 prom_hit, prom_ok;
    logic [CW-1:0]        prom_pos;
    logic [IDW-1:0]       prom_w;
    logic [IDW-1:0]       act2  [MAX_ACTIVE];
    logic [IDW-1:0]       pend2 [NUM_WARPS];
    logic [CW-1:0]        act2_cnt, pend2_cnt;

    always_comb begin
        for (int j = 0; j < NUM_WARPS; j++) begin
            prom_mask[j] = (CW'(j) < pend1_cnt) && !warp_wait[pend1[j]];
        end
    end

    tl_first_set #(.WIDTH(NUM_WARPS), .POSW(CW)) i_prom_pick (
        .mask (prom_mask), .hit (prom_hit), .pos (prom_pos)
    );

    assign prom_ok = prom_hit && (act1_cnt < CW'(MAX_ACTIVE));

    always_comb begin
        act2      = act1;
        pend2     = pend1;
        act2_cnt  = act1_cnt;
        pend2_cnt = pend1_cnt;
        prom_w    = '0;
        for (int k = 0; k < NUM_WARPS; k++) begin
            if (CW'(k) == prom_pos) prom_w = pend1[k];
        end
        if (prom_ok) begin
            for (int k = 0; k < NUM_WARPS - 1; k++) begin
                if (CW'(k) >= prom_pos) pend2[k] = pend1[k+1];
            end
            for (int k = 0; k < MAX_ACTIVE; k++) begin
                if (CW'(k) == act1_cnt) act2[k] = prom_w;
            end
            act2_cnt  = act1_cnt + CW'(1);
            pend2_cnt = pend1_cnt - CW'(1);
        end
    end

    // Step 3: issue scan over the updated active order
    logic [MAX_ACTIVE-1:0] iss_mask;
    logic                  iss_hit;
    logic [CW-1:0]         iss_pos;
    logic [IDW-1:0]        iss_w;
    logic [IDW-1:0]        act3 [MAX_ACTIVE];
    logic [NUM_WARPS-1:0]  flush_d;

    always_comb begin
        for (int i = 0; i < MAX_ACTIVE; i++) begin
            iss_mask[i] = (CW'(i) < act2_cnt) && ready_w[act2[i]];
        end
    end

    tl_first_set #(.WIDTH(MAX_ACTIVE), .POSW(CW)) i_iss_pick (
        .mask (iss_mask), .hit (iss_hit), .pos (iss_pos)
    );

    always_comb begin
        iss_w   = '0;
        flush_d = '0;
        act3    = act2;
        for (int k = 0; k < MAX_ACTIVE; k++) begin
            if (CW'(k) == iss_pos) iss_w = act2[k];
            if ((CW'(k) < act2_cnt) && hazard_w[act2[k]] &&
                (!iss_hit || (CW'(k) < iss_pos))) begin
                flush_d[act2[k]] = 1'b1;
            end
        end
        if (iss_hit) begin
            for (int k = 0; k < MAX_ACTIVE - 1; k++) begin
                if (CW'(k) >= iss_pos) act3[k] = act2[k+1];
            end
            for (int k = 0; k < MAX_ACTIVE; k++) begin
                if (CW'(k) == act2_cnt - CW'(1)) act3[k] = iss_w;
            end
        end
    end

    // List state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < MAX_ACTIVE; k++) act_q[k] <= IDW'(k);
            for (int k = 0; k < NUM_WARPS; k++) begin
                pend_q[k] <= (k < NUM_WARPS - MAX_ACTIVE) ? IDW'(k + MAX_ACTIVE) : '0;
            end
            act_cnt  <= CW'(MAX_ACTIVE);
            pend_cnt <= CW'(NUM_WARPS - MAX_ACTIVE);
        end else begin
            act_q    <= act3;
            pend_q   <= pend2;
            act_cnt  <= act2_cnt;
            pend_cnt <= pend2_cnt;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_vld  <= 1'b0;
            issue_warp <= '0;
            issue_pipe <= PIPE_SP;
            flush_req  <= '0;
        end else begin
            issue_vld  <= iss_hit;
            issue_warp <= iss_hit ? iss_w : '0;
            issue_pipe <= iss_hit ? pipe_w[iss_w] : PIPE_SP;
            flush_req  <= flush_d;
        end
    end
endmodule

// File: rtl/tl_warp_sched_chk.sv
module tl_warp_sched_chk #(
    parameter int NUM_WARPS  = 8,
    parameter int MAX_ACTIVE = 4,
    parameter int CW         = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_WARPS-1:0]         warp_wait,
    input logic [NUM_WARPS-1:0]         inst_valid,
    input logic [NUM_WARPS-1:0]         pc_match,
    input logic [2*NUM_WARPS-1:0]       op_class,
    input logic [NUM_WARPS-1:0]         collide,
    input logic                         sp_free,
    input logic                         sfu_free,
    input logic                         mem_free,
    input logic                         issue_vld,
    input logic [$clog2(NUM_WARPS)-1:0] issue_warp,
    input logic [1:0]                   issue_pipe,
    input logic [NUM_WARPS-1:0]         flush_req,
    input logic [CW-1:0]                act_cnt,
    input logic [CW-1:0]                pend_cnt
);
    // Inputs as sampled at the previous edge
    logic [NUM_WARPS-1:0]   wait_q, valid_q, pcok_q, coll_q;
    logic [2*NUM_WARPS-1:0] op_q;
    logic                   sp_q, sfu_q, mem_q;

    always_ff @(posedge clk) begin
        wait_q  <= warp_wait;
        valid_q <= inst_valid;
        pcok_q  <= pc_match;
        coll_q  <= collide;
        op_q    <= op_class;
        sp_q    <= sp_free;
        sfu_q   <= sfu_free;
        mem_q   <= mem_free;
    end

    logic [1:0] iw_op;
    assign iw_op = op_q[{issue_warp, 1'b0} +: 2];

    assert_mem_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_pipe == 2'b10) |-> (mem_q && iw_op == 2'b11));

    assert_sp_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_pipe == 2'b00) |-> (sp_q && (iw_op == 2'b00 || iw_op == 2'b10)));

    assert_sfu_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_pipe == 2'b01) |->
            (sfu_q && (iw_op == 2'b01 || (iw_op == 2'b10 && !sp_q))));

    assert_ready_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |-> (!wait_q[issue_warp] && valid_q[issue_warp] &&
                       pcok_q[issue_warp] && !coll_q[issue_warp]));

    assert_flush_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req & ~(valid_q & ~pcok_q & ~wait_q)) == '0);

    assert_flush_not_issuer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |-> !flush_req[issue_warp]);

    assert_list_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(act_cnt) <= MAX_ACTIVE) && (int'(act_cnt) + int'(pend_cnt) == NUM_WARPS));
endmodule

bind tl_warp_sched tl_warp_sched_chk #(
    .NUM_WARPS  (NUM_WARPS),
    .MAX_ACTIVE (MAX_ACTIVE),
    .CW         (CW)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .warp_wait  (warp_wait),
    .inst_valid (inst_valid),
    .pc_match   (pc_match),
    .op_class   (op_class),
    .collide    (collide),
    .sp_free    (sp_free),
    .sfu_free   (sfu_free),
    .mem_free   (mem_free),
    .issue_vld  (issue_vld),
    .issue_warp (issue_warp),
    .issue_pipe (issue_pipe),
    .flush_req  (flush_req),
    .act_cnt    (act_cnt),
    .pend_cnt   (pend_cnt)
);

// File: tb/test_tl_warp_sched.sv
module test_tl_warp_sched;
    localparam int CLK_PERIOD = 10;
    localparam int NW  = 8;
    localparam int MA  = 4;
    localparam int NS  = 4;
    localparam int RW  = 6;
    localparam int IDW = $clog2(NW);
    localparam int TW  = 1 + IDW + 2 + NW;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NW-1:0]       warp_wait, inst_valid, pc_match, collide;
    logic [2*NW-1:0]     op_class;
    logic [NW*NS*RW-1:0] src_idx;
    logic [NW*NS-1:0]    src_long;
    logic                sp_free, sfu_free, mem_free;
    logic                issue_vld;
    logic [IDW-1:0]      issue_warp;
    logic [1:0]          issue_pipe;
    logic [NW-1:0]       flush_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference lists
    int m_act [MA];
    int m_pend [NW];
    int m_an, m_pn;
    logic [TW-1:0] exp_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    tl_warp_sched #(.NUM_WARPS(NW), .MAX_ACTIVE(MA), .NUM_SRC(NS), .SRC_IDX_W(RW)) i_tl_warp_sched (
        .clk(clk), .rst_n(rst_n), .warp_wait(warp_wait), .inst_valid(inst_valid),
        .pc_match(pc_match), .op_class(op_class), .collide(collide), .src_idx(src_idx),
        .src_long(src_long), .sp_free(sp_free), .sfu_free(sfu_free), .mem_free(mem_free),
        .issue_vld(issue_vld), .issue_warp(issue_warp), .issue_pipe(issue_pipe),
        .flush_req(flush_req)
    );

    function automatic bit f_stall(int w);
        bit r = warp_wait[w];
        for (int s = 0; s < NS; s++) begin
            if (src_long[w*NS+s] && src_idx[(w*NS+s)*RW +: RW] != 0) r = 1;
        end
        return r;
    endfunction

    function automatic int f_pipe(int w);
        case (op_class[2*w +: 2])
            2'b11:   return mem_free ? 2 : -1;
            2'b01:   return sfu_free ? 1 : -1;
            2'b00:   return sp_free ? 0 : -1;
            default: return sp_free ? 0 : (sfu_free ? 1 : -1);
        endcase
    endfunction

    task automatic model_reset();
        for (int k = 0; k < MA; k++) m_act[k] = k;
        for (int k = 0; k < NW - MA; k++) m_pend[k] = MA + k;
        m_an = MA;
        m_pn = NW - MA;
    endtask

    task automatic model_step();
        int d = -1;
        int v, w, p;
        logic [NW-1:0] fl = '0;
        exp_v = '0;
        for (int i = 0; i < m_an; i++) begin
            if (f_stall(m_act[i])) begin d = i; break; end
        end
        if (d >= 0) begin
            v = m_act[d];
            for (int k = d; k < m_an - 1; k++) m_act[k] = m_act[k+1];
            m_an--;
            m_pend[m_pn] = v;
            m_pn++;
        end
        if (m_an < MA) begin
            for (int j = 0; j < m_pn; j++) begin
                if (!warp_wait[m_pend[j]]) begin
                    v = m_pend[j];
                    for (int k = j; k < m_pn - 1; k++) m_pend[k] = m_pend[k+1];
                    m_pn--;
                    m_act[m_an] = v;
                    m_an++;
                    break;
                end
            end
        end
        for (int i = 0; i < m_an; i++) begin
            w = m_act[i];
            if (warp_wait[w] || !inst_valid[w]) continue;
            if (!pc_match[w]) begin fl[w] = 1'b1; continue; end
            if (collide[w]) continue;
            p = f_pipe(w);
            if (p >= 0) begin
                exp_v[TW-1] = 1'b1;
                exp_v[NW+2 +: IDW] = IDW'(w);
                exp_v[NW +: 2] = 2'(p);
                for (int k = i; k < m_an - 1; k++) m_act[k] = m_act[k+1];
                m_act[m_an-1] = w;
                break;
            end
        end
        exp_v[NW-1:0] = fl;
    endtask

    task automatic check(string tag, logic [TW-1:0] act, logic [TW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [TW-1:0] observed();
        return {issue_vld, issue_vld ? issue_warp : IDW'(0),
                issue_vld ? issue_pipe : 2'b00, flush_req};
    endfunction

    task automatic cyc(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, observed(), exp_v);
    endtask

    task automatic all_ready(logic [1:0] op);
        warp_wait = '0; inst_valid = '1; pc_match = '1; collide = '0;
        for (int w = 0; w < NW; w++) op_class[2*w +: 2] = op;
        src_idx = '0; src_long = '0;
        sp_free = 1'b1; sfu_free = 1'b1; mem_free = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        all_ready(2'b00);
        repeat (2) @(negedge clk);
        check("R1", {issue_vld, flush_req}, '0);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        all_ready(2'b00);
        do_reset();

        // R1 reset order, R10 rotation through active warps only
        cyc("R1");
        for (int n = 0; n < 5; n++) cyc("R10");

        // R2: active warps blocked, pending ones ready but unreachable
        do_reset();
        collide[MA-1:0] = '1;
        cyc("R2"); cyc("R2");

        // R3: waiting warp demoted, pending head promoted
        do_reset();
        warp_wait[1] = 1'b1;
        cyc("R3"); cyc("R3"); cyc("R3");

        // R4: long flag on an unused slot has no effect; on a used slot it demotes
        do_reset();
        src_long[0*NS+0] = 1'b1;
        cyc("R4"); cyc("R4");
        src_long[0*NS+2] = 1'b1;
        src_idx[(0*NS+2)*RW +: RW] = RW'(5);
        cyc("R3"); cyc("R3");

        // R5: no promotion while all pending warps wait, then one
        do_reset();
        warp_wait[NW-1:MA] = '1;
        warp_wait[0] = 1'b1;
        cyc("R5"); cyc("R5");
        warp_wait[MA+2] = 1'b0;
        cyc("R5"); cyc("R5");

        // R6: hazard before issuer flushed, hazard behind issuer not
        do_reset();
        pc_match[0] = 1'b0; pc_match[2] = 1'b0;
        cyc("R6"); cyc("R6");

        // R7: collision skips warp
        do_reset();
        collide[0] = 1'b1;
        cyc("R7"); cyc("R7");

        // R8: memory ops wait for the memory pipe only
        do_reset();
        all_ready(2'b11);
        mem_free = 1'b0;
        cyc("R8");
        mem_free = 1'b1; sp_free = 1'b0; sfu_free = 1'b0;
        cyc("R8"); cyc("R8");

        // R9: pipe preference
        do_reset();
        all_ready(2'b10);
        sp_free = 1'b0;
        cyc("R9");
        sp_free = 1'b1;
        cyc("R9");
        all_ready(2'b01);
        sfu_free = 1'b0;
        cyc("R9");
        all_ready(2'b00);
        sp_free = 1'b0;
        cyc("R9");

        // R11: constrained random traffic, one-cycle registered response
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            for (int w = 0; w < NW; w++) begin
                warp_wait[w]  = ($urandom_range(0, 99) < 25);
                inst_valid[w] = ($urandom_range(0, 99) < 80);
                pc_match[w]   = ($urandom_range(0, 99) < 85);
                collide[w]    = ($urandom_range(0, 99) < 20);
                op_class[2*w +: 2] = 2'($urandom_range(0, 3));
                for (int s = 0; s < NS; s++) begin
                    src_idx[(w*NS+s)*RW +: RW] = RW'($urandom_range(0, 3));
                    src_long[w*NS+s] = ($urandom_range(0, 99) < 6);
                end
            end
            sp_free  = ($urandom_range(0, 99) < 70);
            sfu_free = ($urandom_range(0, 99) < 60);
            mem_free = ($urandom_range(0, 99) < 60);
            cyc("R11");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule